// File: doc/BRIEF.md
# Amplifier Fault Supervisor with DC-Offset Detection

This block supervises the power stage of a two-channel class-D amplifier. It takes comparator flags for over-current and over-temperature, a digitised supply-voltage code, and, once per switching period, each channel's differential duty (in percent) and its polarity. From these it decides whether the output bridge may drive (`out_en`) or must stay in high impedance. It also drives an active-low fault report (`fault_n`) and pulses `start_done` when the turn-on interval ends.

Some faults are latched and reported: over-current, over-temperature, and a DC offset that persists. A latched fault holds the bridge off until the shutdown input `sd_n` is driven low. Supply under-voltage and over-voltage are handled differently. They silence the bridge only while the condition lasts, they are never reported on `fault_n`, and when they end they restart the full turn-on interval. The DC-offset detector counts switching periods in which one channel's duty stays above the threshold at one polarity.

All inputs pass through two-stage synchronisers. Time is counted in ticks of about 1 µs, which are divided down from the system clock. All control and status pins are plain level signals. The block has no streaming interface, so it has no back-pressure.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While and just after reset, `out_en` is 0, `fault_n` is 1 and `start_done` is 0.
- R2: While `sd_n` is low, `out_en` is 0 and every latched fault is cleared. Over-current or over-temperature flags seen only during shutdown leave `fault_n` at 1 after release.
- R3: After `sd_n` rises, `out_en` rises once `TURNON_TICKS` ticks have elapsed and no hold condition is present. `start_done` is high for exactly one cycle, in the same cycle that `out_en` rises.
- R4: An over-current or over-temperature flag that is high for even one cycle drives `fault_n` low and `out_en` low. Both stay that way after the flag drops.
- R5: Latched faults clear only when `sd_n` goes low. Several faults latched together are all cleared by a single low period of `sd_n`.
- R6: A channel's duty counts toward a DC fault when it is strictly above `DC_THR_PCT` (default 60, in percent). The duty port is an unsigned percent value from 0 to 100. A DC fault latches once more than `DC_PERIODS` consecutive strobes of one channel have counted at the same polarity. Exactly `DC_PERIODS` such strobes do not trip.
- R7: A channel's DC count restarts when its polarity changes, and is cleared when its duty is at or below `DC_THR_PCT`.
- R8: A supply code below `UV_CODE` or above `OV_CODE` forces `out_en` to 0 within three cycles, and `fault_n` stays 1. With one code step equal to 0.25 V, the defaults are 18 (4.5 V) and 108 (27 V).
- R9: When the supply code returns inside the range, the complete turn-on interval runs again before `out_en` rises. No shutdown cycle is needed.
- R10: The left and right channels are checked independently, and either one can raise the DC fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_n | input | 1 | Shutdown, active low; a low period clears latched faults |
| oc_flag | input | 1 | Over-current comparator flag |
| ot_flag | input | 1 | Over-temperature comparator flag |
| vsup_code | input | VSUP_W | Supply voltage code, 0.25 V per step |
| period_stb | input | 1 | One-cycle strobe per switching period |
| duty_l | input | DUTY_W | Left channel differential duty, percent |
| pol_l | input | 1 | Left channel duty polarity |
| duty_r | input | DUTY_W | Right channel differential duty, percent |
| pol_r | input | 1 | Right channel duty polarity |
| out_en | output | 1 | Bridge drive enable; 0 means high impedance |
| fault_n | output | 1 | Active-low latched fault report |
| start_done | output | 1 | One-cycle pulse when the turn-on interval completes |

## Verification
Two functions of this block can act in the same cycle: a latched fault and a self-clearing supply fault. The bench provokes this by raising the over-current flag in the same cycle as an under-voltage code. It then restores the supply and checks that the bridge stays silent and `fault_n` stays low until a shutdown cycle. A DC trip and a shutdown release can also coincide, so the bench sweeps every duty value across the threshold and cycles shutdown after each trip. It then checks that the following turn-on interval lands inside the window computed from the tick period.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_t;

  localparam int FLT_OC = 0;
  localparam int FLT_OT = 1;
  localparam int FLT_DC = 2;
  localparam int FLT_N  = 3;
endpackage

// File: rtl/afs_sync.sv
module afs_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/afs_tick.sv
module afs_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DIV - 1)); // R3
endmodule

// File: rtl/afs_dc_chan.sv
module afs_dc_chan #(
  parameter int DUTY_W = 7,
  parameter int THR    = 60,
  parameter int LIMIT  = 168000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic [DUTY_W-1:0] duty,
  input  logic              pol,
  output logic              trip
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);

  logic [CW-1:0] run_cnt;
  logic          run_pol;
  logic          over;

  assign over = (duty > DUTY_W'(THR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_pol <= 1'b0;
    end else if (clr) begin
      run_cnt <= '0;
    end else if (stb) begin
      if (!over) begin
        run_cnt <= '0;
      end else if (run_cnt == '0 || pol != run_pol) begin
        run_cnt <= CW'(1);
        run_pol <= pol;
      end else if (run_cnt != TOP) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign trip = (run_cnt == TOP);

  AST_DC_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb && !over) |=> (run_cnt == '0 && !trip)); // R7
  AST_DC_FLIP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb && over && run_cnt != '0 && pol != run_pol) |=> (run_cnt == CW'(1))); // R7
  AST_DC_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && !stb) |=> !trip); // R6
endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int VSUP_W       = 8,
  parameter int DUTY_W       = 7,
  parameter int CLK_PER_TICK = 100,
  parameter int TURNON_TICKS = 10000,
  parameter int DC_THR_PCT   = 60,
  parameter int DC_PERIODS   = 168000,
  parameter int UV_CODE      = 18,
  parameter int OV_CODE      = 108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_n,
  input  logic              oc_flag,
  input  logic              ot_flag,
  input  logic [VSUP_W-1:0] vsup_code,
  input  logic              period_stb,
  input  logic [DUTY_W-1:0] duty_l,
  input  logic              pol_l,
  input  logic [DUTY_W-1:0] duty_r,
  input  logic              pol_r,
  output logic              out_en,
  output logic              fault_n,
  output logic              start_done
);
  import afs_pkg::*;

  localparam int NCH  = 2;
  localparam int SW   = 3 + VSUP_W + NCH * (DUTY_W + 1);
  localparam int RW   = $clog2(TURNON_TICKS + 1);

  // synchronised inputs
  logic [SW-1:0]     raw_bus, syn_bus;
  logic              sd_s, oc_s, ot_s, stb_s;
  logic [VSUP_W-1:0] vsup_s;
  logic [DUTY_W-1:0] duty_s [NCH];
  logic              pol_s  [NCH];

  assign raw_bus = {oc_flag, ot_flag, period_stb, vsup_code,
                    duty_l, pol_l, duty_r, pol_r};

  afs_sync #(.W(SW), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus));

  afs_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sd (
    .clk(clk), .rst_n(rst_n), .d(sd_n), .q(sd_s));

  assign {oc_s, ot_s, stb_s, vsup_s, duty_s[0], pol_s[0], duty_s[1], pol_s[1]} = syn_bus;

  // time base
  logic tick;
  afs_tick #(.DIV(CLK_PER_TICK)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  // per-channel DC-offset qualification
  logic [NCH-1:0] dc_trip;
  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_dc
      afs_dc_chan #(.DUTY_W(DUTY_W), .THR(DC_THR_PCT), .LIMIT(DC_PERIODS)) u_dc (
        .clk(clk), .rst_n(rst_n), .clr(!sd_s), .stb(stb_s),
        .duty(duty_s[ch]), .pol(pol_s[ch]), .trip(dc_trip[ch]));
    end
  endgenerate

  // latched fault set
  logic [FLT_N-1:0] lat;
  logic [FLT_N-1:0] lat_set;

  always_comb begin
    lat_set         = '0;
    lat_set[FLT_OC] = oc_s;
    lat_set[FLT_OT] = ot_s;
    lat_set[FLT_DC] = |dc_trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat <= '0;
    else if (!sd_s) lat <= '0;
    else            lat <= lat | lat_set;
  end

  // self-clearing supply window
  logic sup_bad, hold;
  assign sup_bad = (vsup_s < VSUP_W'(UV_CODE)) || (vsup_s > VSUP_W'(OV_CODE));
  assign hold    = sup_bad || (|lat);

  // turn-on sequencer
  pwr_state_t    state;
  logic [RW-1:0] ramp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PWR_OFF;
      ramp       <= '0;
      start_done <= 1'b0;
    end else begin
      start_done <= 1'b0;
      if (!sd_s) begin
        state <= PWR_OFF;
        ramp  <= '0;
      end else begin
        case (state)
          PWR_OFF: begin
            state <= PWR_WAIT;
            ramp  <= '0;
          end
          PWR_WAIT: begin
            if (hold) begin
              ramp <= '0;
            end else if (tick) begin
              if (ramp == RW'(TURNON_TICKS - 1)) begin
                state      <= PWR_ON;
                ramp       <= '0;
                start_done <= 1'b1;
              end else begin
                ramp <= ramp + 1'b1;
              end
            end
          end
          PWR_ON: begin
            if (hold) begin
              state <= PWR_WAIT;
              ramp  <= '0;
            end
          end
          default: begin
            state <= PWR_OFF;
            ramp  <= '0;
          end
        endcase
      end
    end
  end

  assign out_en  = (state == PWR_ON) && !hold;
  assign fault_n = ~(|lat);

  AST_SD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_s |=> !out_en); // R2
  AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !out_en); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && sd_s) |=> !fault_n); // R5
  AST_SUPPLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    sup_bad |-> !out_en); // R8
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> !start_done); // R3
  AST_RISE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> start_done); // R3
  AST_NO_EARLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_WAIT) |-> !out_en); // R9
endmodule

// File: tb/amp_fault_supervisor_test.sv
module amp_fault_supervisor_test;
  localparam int TPT    = 4;
  localparam int TON    = 10;
  localparam int DCP    = 5;
  localparam int THR    = 60;
  localparam int UVC    = 18;
  localparam int OVC    = 108;
  localparam int GOOD   = 48;
  // release-to-enable window: 2 sync + 1 state + TON ticks of TPT clocks
  localparam int WIN_LO = 3 + (TON - 1) * TPT;
  localparam int WIN_HI = 3 + TON * TPT + 2;

  logic       clk = 1'b0;
  logic       rst_n, sd_n, oc_flag, ot_flag, period_stb, pol_l, pol_r;
  logic [7:0] vsup_code;
  logic [6:0] duty_l, duty_r;
  logic       out_en, fault_n, start_done;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  amp_fault_supervisor #(
    .VSUP_W(8), .DUTY_W(7), .CLK_PER_TICK(TPT), .TURNON_TICKS(TON),
    .DC_THR_PCT(THR), .DC_PERIODS(DCP), .UV_CODE(UVC), .OV_CODE(OVC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sd_n(sd_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .vsup_code(vsup_code), .period_stb(period_stb), .duty_l(duty_l), .pol_l(pol_l),
    .duty_r(duty_r), .pol_r(pol_r), .out_en(out_en), .fault_n(fault_n),
    .start_done(start_done));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // counts cycles until out_en rises; checks start_done coincides
  task automatic wait_on(output int n);
    n = 0;
    while (!out_en && n < 300) begin
      step(1);
      n++;
    end
    chk("R3 start_done with out_en", int'(start_done), 1);
    step(1);
    chk("R3 start_done one cycle", int'(start_done), 0);
  endtask

  task automatic sd_cycle();
    sd_n = 1'b0;
    step(4);
    chk("R2 out_en low in shutdown", int'(out_en), 0);
    chk("R5 fault cleared by shutdown", int'(fault_n), 1);
    sd_n = 1'b1;
  endtask

  task automatic strobe(input int dl, input bit pl, input int dr, input bit pr);
    duty_l = 7'(dl); pol_l = pl; duty_r = 7'(dr); pol_r = pr;
    period_stb = 1'b1;
    step(1);
    period_stb = 1'b0;
    step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; sd_n = 1'b0; oc_flag = 1'b0; ot_flag = 1'b0;
    vsup_code = 8'(GOOD); period_stb = 1'b0;
    duty_l = '0; duty_r = '0; pol_l = 1'b0; pol_r = 1'b0;
    step(3);
    chk("R1 out_en in reset", int'(out_en), 0);
    chk("R1 fault_n in reset", int'(fault_n), 1);
    chk("R1 start_done in reset", int'(start_done), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 out_en after reset", int'(out_en), 0);
    chk("R1 fault_n after reset", int'(fault_n), 1);

    // R3: turn-on interval
    sd_n = 1'b1;
    step(WIN_LO - 2);
    chk("R3 out_en still low early", int'(out_en), 0);
    wait_on(n);
    chk_rng("R3 turn-on latency", n + WIN_LO - 2, WIN_LO, WIN_HI);

    // R4: over-current single-cycle pulse
    oc_flag = 1'b1; step(1); oc_flag = 1'b0;
    step(4);
    chk("R4 oc fault_n", int'(fault_n), 0);
    chk("R4 oc out_en", int'(out_en), 0);
    step(60);
    chk("R4 oc stays latched", int'(fault_n), 0);
    chk("R5 no recovery without shutdown", int'(out_en), 0);
    sd_cycle();
    wait_on(n);
    chk_rng("R5 ramp after clear", n, WIN_LO, WIN_HI);

    // R4: over-temperature
    ot_flag = 1'b1; step(1); ot_flag = 1'b0;
    step(4);
    chk("R4 ot fault_n", int'(fault_n), 0);
    chk("R4 ot out_en", int'(out_en), 0);

    // R5: second latched fault together, single clear
    oc_flag = 1'b1; step(2); oc_flag = 1'b0;
    step(40);
    chk("R5 both latched", int'(fault_n), 0);
    sd_cycle();
    wait_on(n);
    chk("R5 single shutdown clears all", int'(fault_n), 1);

    // R2: flags during shutdown are not latched
    sd_n = 1'b0;
    step(4);
    ot_flag = 1'b1; oc_flag = 1'b1; step(2); ot_flag = 1'b0; oc_flag = 1'b0;
    step(4);
    chk("R2 out_en low while shut down", int'(out_en), 0);
    sd_n = 1'b1;
    wait_on(n);
    chk("R2 flag in shutdown ignored", int'(fault_n), 1);
    chk("R2 outputs enabled after release", int'(out_en), 1);

    // R6: duty sweep on left channel, boundary at DCP strobes
    for (int d = 0; d <= 100; d++) begin
      strobe(0, 1'b0, 0, 1'b0);
      for (int k = 0; k < DCP; k++) strobe(d, 1'b1, 0, 1'b0);
      chk($sformatf("R6 no trip at limit duty %0d", d), int'(fault_n), 1);
      strobe(d, 1'b1, 0, 1'b0);
      chk($sformatf("R6 trip past limit duty %0d", d), int'(fault_n), (d > THR) ? 0 : 1);
      if (d > THR) begin
        chk("R6 dc out_en", int'(out_en), 0);
        strobe(0, 1'b0, 0, 1'b0);
        sd_cycle();
        wait_on(n);
      end
    end

    // R10: right channel alone, both polarities
    for (int p = 0; p < 2; p++) begin
      strobe(0, 1'b0, 0, 1'b0);
      for (int k = 0; k < DCP; k++) strobe(30, 1'b0, 61, 1'(p));
      chk("R10 right no trip at limit", int'(fault_n), 1);
      strobe(30, 1'b0, 61, 1'(p));
      chk("R10 right channel trips", int'(fault_n), 0);
      strobe(0, 1'b0, 0, 1'b0);
      sd_cycle();
      wait_on(n);
    end

    // R7: polarity change restarts count
    strobe(0, 1'b0, 0, 1'b0);
    for (int k = 0; k < 3; k++) strobe(80, 1'b1, 0, 1'b0);
    for (int k = 0; k < DCP; k++) strobe(80, 1'b0, 0, 1'b0);
    chk("R7 polarity flip restarts", int'(fault_n), 1);
    strobe(80, 1'b0, 0, 1'b0);
    chk("R7 trip after restarted run", int'(fault_n), 0);
    strobe(0, 1'b0, 0, 1'b0);
    sd_cycle();
    wait_on(n);

    // R7: duty at threshold clears count
    for (int k = 0; k < 3; k++) strobe(90, 1'b1, 0, 1'b0);
    strobe(THR, 1'b1, 0, 1'b0);
    for (int k = 0; k < DCP; k++) strobe(90, 1'b1, 0, 1'b0);
    chk("R7 threshold duty clears", int'(fault_n), 1);
    strobe(90, 1'b1, 0, 1'b0);
    chk("R7 trip after cleared run", int'(fault_n), 0);
    strobe(0, 1'b0, 0, 1'b0);
    sd_cycle();
    wait_on(n);

    // R8/R9: supply code sweep
    for (int c = 0; c < 256; c++) begin
      vsup_code = 8'(c);
      step(4);
      chk($sformatf("R8 out_en code %0d", c), int'(out_en), (c < UVC || c > OVC) ? 0 : 1);
      chk($sformatf("R8 fault_n code %0d", c), int'(fault_n), 1);
      if (c < UVC || c > OVC) begin
        vsup_code = 8'(GOOD);
        wait_on(n);
        chk_rng($sformatf("R9 full restart code %0d", c), n, WIN_LO, WIN_HI);
      end
    end

    // latched and self-clearing in the same cycle
    vsup_code = 8'(10); oc_flag = 1'b1;
    step(1);
    oc_flag = 1'b0;
    step(4);
    vsup_code = 8'(GOOD);
    step(WIN_HI + 10);
    chk("R4 latched outlives supply recovery", int'(out_en), 0);
    chk("R4 fault_n still low", int'(fault_n), 0);
    sd_cycle();
    wait_on(n);
    chk("R5 clear after combined fault", int'(fault_n), 1);
    chk_rng("R9 ramp after combined fault", n, WIN_LO, WIN_HI);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule